// File: doc/BRIEF.md
# Feed-Forward Gate Netlist Evaluator

This block holds a small acyclic netlist of two-input logic nodes and evaluates it in hardware on a set of primary input bits. Every value the netlist can use lives in one flat index space. Index 0 is a fixed logic 0 and index 1 is a fixed logic 1. The primary input bits come next, and after them the node results. A node may only read values whose index is lower than its own. The netlist therefore always evaluates in a single pass, in the order it was stored.

Software or a loader fills the netlist through one write port. It appends nodes, fills the output selector table, and sets the declared input and output bit counts. Afterwards a one-cycle `start` pulse runs the evaluation. The engine processes one node per clock and writes each result into a value register. It then gathers the selected values into the output word `y` and pulses `done`. If the netlist is malformed, or the inputs do not match the declared count, `err` is raised and `y` reads zero.

Top module: `gate_netlist_eval`

## Requirements
- R1: A selector of 0 yields logic 0 and a selector of 1 yields logic 1 in the output word.
- R2: Primary input bit values occupy indices from 2 upward. The `a_len` low bits of `in_a` come first, least significant bit first. The `b_len` low bits of `in_b` follow in the same order.
- R3: If `a_len + b_len` differs from the declared input count, no node is evaluated. `err` is raised and `done` pulses in the first cycle after the start edge.
- R4: A node whose first or second source index is not strictly below its own index is an error. So is a node whose own index is 2+MAX_IN+MAX_NODES or more.
- R5: Function codes on `wr_fn` are: 0 pass source A, 1 invert A, 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 XNOR, 8 constant 1, 9 constant 0. Codes 0, 1, 8 and 9 do not use source B.
- R6: A node that targets an index already holding a value is an error. This covers a constant, a declared input bit, or an earlier node.
- R7: Function codes 10 to 15 are an error.
- R8: Output bit k equals the value at the index held by selector k, for k below the declared output count. Higher bits read 0. A used selector at or above 2+MAX_IN+MAX_NODES, or an output count above MAX_OUT, is an error.
- R9: With N stored nodes and no error, `done` is high for exactly one cycle, N+1 cycles after the start edge (1 cycle when N is 0). If node j (counting from 0) is the first faulty node, `done` comes j+2 cycles after the start edge. `busy` is high from the start edge until `done`.
- R10: After any error, `done` still pulses and `y` is zero. `err` stays high until the next start.
- R11: Netlist writes and `start` pulses are ignored while `busy` is high.
- R12: Write op 0 appends a node (`wr_id`, `wr_src_a`, `wr_src_b`, `wr_fn`) and is ignored once MAX_NODES nodes are stored. Op 1 sets selector `wr_slot` to `wr_src_a`. Op 2 sets the input count to `wr_src_a` and the output count to `wr_slot`. Op 3 empties the node list.
- R13: Synchronous active-high reset clears `done`, `err`, `busy`, `y`, the value register, the node count, both declared counts and all selectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Netlist write strobe |
| wr_op | input | 2 | Write operation (node, selector, header, clear) |
| wr_id | input | IDXW | Node's own index |
| wr_src_a | input | IDXW | Source A index / selector value / input count |
| wr_src_b | input | IDXW | Source B index |
| wr_fn | input | 4 | Node function code |
| wr_slot | input | SLW | Selector slot / output count |
| start | input | 1 | Evaluation start pulse |
| in_a | input | MAX_IN | First operand bits |
| a_len | input | LW | Number of used bits of `in_a` |
| in_b | input | MAX_IN | Second operand bits |
| b_len | input | LW | Number of used bits of `in_b` |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Malformed netlist or input count mismatch |
| y | output | MAX_OUT | Gathered output word |

## Verification
The bench targets several kinds of netlist fault:

- **Source ordering:** a node whose source equals its own index must fail. A design checking `<=` would run it and return a value.
- **Index collisions:** a node landing on a declared input index, and a second node on the same index, must both fail. A design without an occupancy record would overwrite the input bit instead.
- **Illegal codes and stray selectors:** these must also flag an error.
- **Error latency:** `done` must arrive at exactly the cycle the requirements give. An engine that ran on after an error, or stopped a node early or late, would miscompare on `done`.

The bench also checks where the second operand's bits start after a variable-length first operand, and that bits above the output count stay zero. It fills the node table past its capacity, which a design without saturation would lengthen by one cycle. Finally it writes a clear and a start during a run; a design that accepted either would change the next run's latency.

// File: rtl/gne_pkg.sv
package gne_pkg;

    typedef enum logic [1:0] {
        OP_NODE = 2'd0,
        OP_OSEL = 2'd1,
        OP_HDR  = 2'd2,
        OP_CLR  = 2'd3
    } wop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

    localparam logic [3:0] FN_LAST = 4'd9;

    function automatic logic gate_fn(input logic [3:0] f, input logic a, input logic b);
        logic r;
        case (f)
            4'd0:    r = a;
            4'd1:    r = ~a;
            4'd2:    r = a & b;
            4'd3:    r = a | b;
            4'd4:    r = a ^ b;
            4'd5:    r = ~(a & b);
            4'd6:    r = ~(a | b);
            4'd7:    r = ~(a ^ b);
            4'd8:    r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gne_store.sv
module gne_store
    import gne_pkg::*;
#(
    parameter int MAX_NODES = 16,
    parameter int MAX_OUT   = 8,
    parameter int IDXW      = 5,
    parameter int NCW       = 5,
    parameter int NPW       = 4,
    parameter int SLW       = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_ok,
    input  logic [1:0]                wr_op,
    input  logic [IDXW-1:0]           wr_id,
    input  logic [IDXW-1:0]           wr_src_a,
    input  logic [IDXW-1:0]           wr_src_b,
    input  logic [3:0]                wr_fn,
    input  logic [SLW-1:0]            wr_slot,
    input  logic [NPW-1:0]            rd_ptr,
    output logic [IDXW-1:0]           nd_id,
    output logic [IDXW-1:0]           nd_a,
    output logic [IDXW-1:0]           nd_b,
    output logic [3:0]                nd_fn,
    output logic [NCW-1:0]            node_cnt,
    output logic [IDXW-1:0]           in_cnt,
    output logic [SLW-1:0]            out_cnt,
    output logic [MAX_OUT*IDXW-1:0]   sel_flat
);
    localparam int SIW = $clog2(MAX_OUT);

    logic [IDXW-1:0] t_id  [MAX_NODES];
    logic [IDXW-1:0] t_a   [MAX_NODES];
    logic [IDXW-1:0] t_b   [MAX_NODES];
    logic [3:0]      t_fn  [MAX_NODES];
    logic [IDXW-1:0] sel_q [MAX_OUT];

    wop_e op;
    logic do_wr, room;

    assign op    = wop_e'(wr_op);
    assign do_wr = wr_en && wr_ok;
    assign room  = node_cnt < NCW'(MAX_NODES);

    always_ff @(posedge clk) begin
        if (do_wr && op == OP_NODE && room) begin
            t_id[node_cnt[NPW-1:0]] <= wr_id;
            t_a[node_cnt[NPW-1:0]]  <= wr_src_a;
            t_b[node_cnt[NPW-1:0]]  <= wr_src_b;
            t_fn[node_cnt[NPW-1:0]] <= wr_fn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            node_cnt <= '0;
            in_cnt   <= '0;
            out_cnt  <= '0;
            for (int k = 0; k < MAX_OUT; k++) sel_q[k] <= '0;
        end else if (do_wr) begin
            case (op)
                OP_NODE: if (room) node_cnt <= node_cnt + 1'b1;
                OP_OSEL: if (32'(wr_slot) < MAX_OUT) sel_q[wr_slot[SIW-1:0]] <= wr_src_a;
                OP_HDR: begin
                    in_cnt  <= wr_src_a;
                    out_cnt <= wr_slot;
                end
                default: node_cnt <= '0;
            endcase
        end
    end

    assign nd_id = t_id[rd_ptr];
    assign nd_a  = t_a[rd_ptr];
    assign nd_b  = t_b[rd_ptr];
    assign nd_fn = t_fn[rd_ptr];

    for (genvar k = 0; k < MAX_OUT; k++) begin : g_sel
        assign sel_flat[k*IDXW +: IDXW] = sel_q[k];
    end

    p_wr_blocked_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |=> $stable(node_cnt));

    p_cnt_sat_r12: assert property (@(posedge clk) disable iff (rst)
        node_cnt <= NCW'(MAX_NODES));

endmodule

// File: rtl/gne_node.sv
module gne_node
    import gne_pkg::*;
#(
    parameter int NVAL = 26,
    parameter int IDXW = 5
) (
    input  logic [NVAL-1:0] vals,
    input  logic [NVAL-1:0] asg,
    input  logic [IDXW-1:0] nd_id,
    input  logic [IDXW-1:0] nd_a,
    input  logic [IDXW-1:0] nd_b,
    input  logic [3:0]      nd_fn,
    output logic            res,
    output logic            bad
);
    localparam int VSPAN = 1 << IDXW;

    logic [VSPAN-1:0] vx, ax;

    always_comb begin
        vx    = VSPAN'(vals);
        vx[0] = 1'b0;
        vx[1] = 1'b1;
        ax    = VSPAN'(asg);
    end

    assign res = gate_fn(nd_fn, vx[nd_a], vx[nd_b]);
    assign bad = (32'(nd_id) >= NVAL) || (nd_a >= nd_id) || (nd_b >= nd_id)
               || ax[nd_id] || (nd_fn > FN_LAST);

endmodule

// File: rtl/gne_gather.sv
module gne_gather #(
    parameter int NVAL    = 26,
    parameter int IDXW    = 5,
    parameter int MAX_OUT = 8,
    parameter int SLW     = 4
) (
    input  logic [NVAL-1:0]         vals,
    input  logic [MAX_OUT*IDXW-1:0] sel_flat,
    input  logic [SLW-1:0]          out_cnt,
    output logic [MAX_OUT-1:0]      word,
    output logic                    bad
);
    localparam int VSPAN = 1 << IDXW;

    logic [VSPAN-1:0]   vx;
    logic [MAX_OUT-1:0] bad_k;

    always_comb begin
        vx    = VSPAN'(vals);
        vx[0] = 1'b0;
        vx[1] = 1'b1;
    end

    for (genvar k = 0; k < MAX_OUT; k++) begin : g_bit
        logic [IDXW-1:0] sk;
        logic            used;
        assign sk       = sel_flat[k*IDXW +: IDXW];
        assign used     = 32'(out_cnt) > k;
        assign word[k]  = used && vx[sk];
        assign bad_k[k] = used && (32'(sk) >= NVAL);
    end

    assign bad = (|bad_k) || (32'(out_cnt) > MAX_OUT);

endmodule

// File: rtl/gate_netlist_eval.sv
module gate_netlist_eval
    import gne_pkg::*;
#(
    parameter  int MAX_IN    = 8,
    parameter  int MAX_NODES = 16,
    parameter  int MAX_OUT   = 8,
    localparam int NVAL      = 2 + MAX_IN + MAX_NODES,
    localparam int IDXW      = $clog2(NVAL),
    localparam int SLW       = $clog2(MAX_OUT + 1),
    localparam int LW        = $clog2(MAX_IN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_op,
    input  logic [IDXW-1:0]    wr_id,
    input  logic [IDXW-1:0]    wr_src_a,
    input  logic [IDXW-1:0]    wr_src_b,
    input  logic [3:0]         wr_fn,
    input  logic [SLW-1:0]     wr_slot,
    input  logic               start,
    input  logic [MAX_IN-1:0]  in_a,
    input  logic [LW-1:0]      a_len,
    input  logic [MAX_IN-1:0]  in_b,
    input  logic [LW-1:0]      b_len,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [MAX_OUT-1:0] y
);
    localparam int NCW = $clog2(MAX_NODES + 1);
    localparam int NPW = $clog2(MAX_NODES);

    st_e                     st;
    logic [NPW-1:0]          ptr;
    logic [NVAL-1:0]         vals, asg;
    logic [IDXW-1:0]         nd_id, nd_a, nd_b;
    logic [3:0]              nd_fn;
    logic [NCW-1:0]          node_cnt;
    logic [IDXW-1:0]         in_cnt;
    logic [SLW-1:0]          out_cnt;
    logic [MAX_OUT*IDXW-1:0] sel_flat;
    logic                    nres, nbad, gbad, mismatch;
    logic [MAX_OUT-1:0]      gword;
    logic [NVAL-1:0]         ld_vals, ld_asg;
    logic [2*MAX_IN-1:0]     stream;

    assign busy = (st != ST_IDLE);

    gne_store #(
        .MAX_NODES(MAX_NODES), .MAX_OUT(MAX_OUT), .IDXW(IDXW),
        .NCW(NCW), .NPW(NPW), .SLW(SLW)
    ) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ok(!busy), .wr_op(wr_op),
        .wr_id(wr_id), .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_fn(wr_fn),
        .wr_slot(wr_slot), .rd_ptr(ptr), .nd_id(nd_id), .nd_a(nd_a), .nd_b(nd_b),
        .nd_fn(nd_fn), .node_cnt(node_cnt), .in_cnt(in_cnt), .out_cnt(out_cnt),
        .sel_flat(sel_flat)
    );

    gne_node #(.NVAL(NVAL), .IDXW(IDXW)) u_node (
        .vals(vals), .asg(asg), .nd_id(nd_id), .nd_a(nd_a), .nd_b(nd_b),
        .nd_fn(nd_fn), .res(nres), .bad(nbad)
    );

    gne_gather #(.NVAL(NVAL), .IDXW(IDXW), .MAX_OUT(MAX_OUT), .SLW(SLW)) u_gather (
        .vals(vals), .sel_flat(sel_flat), .out_cnt(out_cnt), .word(gword), .bad(gbad)
    );

    // Input loading: used bits of in_a, then used bits of in_b right behind them.
    always_comb begin
        logic [MAX_IN-1:0] amask, bmask;
        amask    = ~({MAX_IN{1'b1}} << a_len);
        bmask    = ~({MAX_IN{1'b1}} << b_len);
        stream   = (2*MAX_IN)'(in_a & amask) | ((2*MAX_IN)'(in_b & bmask) << a_len);
        mismatch = (32'(a_len) + 32'(b_len) != 32'(in_cnt))
                || (32'(a_len) + 32'(b_len) > MAX_IN);
        ld_vals    = '0;
        ld_asg     = '0;
        ld_vals[1] = 1'b1;
        ld_asg[0]  = 1'b1;
        ld_asg[1]  = 1'b1;
        for (int i = 0; i < MAX_IN; i++) begin
            ld_vals[2+i] = stream[i];
            ld_asg[2+i]  = (i < 32'(in_cnt));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ptr  <= '0;
            vals <= '0;
            asg  <= '0;
            err  <= 1'b0;
            done <= 1'b0;
            y    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    err  <= mismatch;
                    vals <= ld_vals;
                    asg  <= ld_asg;
                    ptr  <= '0;
                    st   <= (mismatch || node_cnt == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (nbad) begin
                        err <= 1'b1;
                        st  <= ST_FIN;
                    end else begin
                        vals[nd_id] <= nres;
                        asg[nd_id]  <= 1'b1;
                        if (NCW'(ptr) + 1'b1 == node_cnt) st <= ST_FIN;
                        else ptr <= ptr + 1'b1;
                    end
                end
                default: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                    if (err || gbad) begin
                        err <= 1'b1;
                        y   <= '0;
                    end else begin
                        y <= gword;
                    end
                end
            endcase
        end
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy && $past(busy));

    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (y == '0));

    p_ptr_bound_r12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (NCW'(ptr) < node_cnt));

endmodule

// File: tb/gate_netlist_eval_tb.sv
module gate_netlist_eval_tb;
    localparam int MAX_IN = 8, MAX_NODES = 16, MAX_OUT = 8;
    localparam int NVAL = 2 + MAX_IN + MAX_NODES;
    localparam int IDXW = $clog2(NVAL);
    localparam int SLW  = $clog2(MAX_OUT + 1);
    localparam int LW   = $clog2(MAX_IN + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, start = 1'b0;
    logic [1:0] wr_op = '0;
    logic [IDXW-1:0] wr_id = '0, wr_src_a = '0, wr_src_b = '0;
    logic [3:0] wr_fn = '0;
    logic [SLW-1:0] wr_slot = '0;
    logic [MAX_IN-1:0] in_a = '0, in_b = '0;
    logic [LW-1:0] a_len = '0, b_len = '0;
    logic busy, done, err;
    logic [MAX_OUT-1:0] y;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // behavioural model state
    int m_id[$], m_a[$], m_b[$], m_fn[$];
    int m_in_cnt = 0, m_out_cnt = 0;
    int m_sel[MAX_OUT];

    always #2.5 clk = ~clk;

    gate_netlist_eval #(.MAX_IN(MAX_IN), .MAX_NODES(MAX_NODES), .MAX_OUT(MAX_OUT)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_id(wr_id),
        .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .wr_fn(wr_fn), .wr_slot(wr_slot),
        .start(start), .in_a(in_a), .a_len(a_len), .in_b(in_b), .b_len(b_len),
        .busy(busy), .done(done), .err(err), .y(y)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_id.delete(); m_a.delete(); m_b.delete(); m_fn.delete();
        m_in_cnt = 0; m_out_cnt = 0;
        for (int k = 0; k < MAX_OUT; k++) m_sel[k] = 0;
    endfunction

    function automatic int gfn(int f, int a, int b);
        case (f)
            0: return a;
            1: return 1 - a;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return 1 - (a & b);
            6: return 1 - (a | b);
            7: return 1 - (a ^ b);
            8: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic model_eval(input int a, input int al, input int b, input int bl,
                              output int lat, output bit e, output int yw);
        int v[NVAL];
        bit s[NVAL];
        int pos;
        e = 0; yw = 0;
        for (int i = 0; i < NVAL; i++) begin v[i] = 0; s[i] = 0; end
        if (al + bl != m_in_cnt || al + bl > MAX_IN) begin
            e = 1; lat = 1;
        end else begin
            v[1] = 1; s[0] = 1; s[1] = 1;
            pos = 2;
            for (int i = 0; i < al; i++) begin v[pos] = (a >> i) & 1; pos++; end
            for (int i = 0; i < bl; i++) begin v[pos] = (b >> i) & 1; pos++; end
            for (int i = 0; i < m_in_cnt; i++) s[2+i] = 1;
            lat = m_id.size() + 1;
            foreach (m_id[j]) begin
                int id;
                id = m_id[j];
                if (id >= NVAL || m_a[j] >= id || m_b[j] >= id || s[id] || m_fn[j] > 9) begin
                    e = 1; lat = j + 2; break;
                end
                v[id] = gfn(m_fn[j], v[m_a[j]], v[m_b[j]]);
                s[id] = 1;
            end
            if (!e) begin
                if (m_out_cnt > MAX_OUT) e = 1;
                else for (int k = 0; k < m_out_cnt; k++) begin
                    if (m_sel[k] >= NVAL) e = 1;
                    else yw |= v[m_sel[k]] << k;
                end
            end
        end
        if (e) yw = 0;
    endtask

    task automatic wr(input int op, input int id, input int sa, input int sb, input int fn, input int slot);
        @(negedge clk);
        wr_en = 1; wr_op = 2'(op); wr_id = IDXW'(id); wr_src_a = IDXW'(sa);
        wr_src_b = IDXW'(sb); wr_fn = 4'(fn); wr_slot = SLW'(slot);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr_node(input int id, input int sa, input int sb, input int fn);
        wr(0, id, sa, sb, fn, 0);
        if (m_id.size() < MAX_NODES) begin
            m_id.push_back(id); m_a.push_back(sa); m_b.push_back(sb); m_fn.push_back(fn);
        end
    endtask

    task automatic wr_sel(input int k, input int idx);
        wr(1, 0, idx, 0, 0, k);
        if (k < MAX_OUT) m_sel[k] = idx;
    endtask

    task automatic wr_hdr(input int ic, input int oc);
        wr(2, 0, ic, 0, 0, oc);
        m_in_cnt = ic; m_out_cnt = oc;
    endtask

    task automatic wr_clr();
        wr(3, 0, 0, 0, 0, 0);
        m_id.delete(); m_a.delete(); m_b.delete(); m_fn.delete();
    endtask

    // Pulse start and compare against the model on every clock until done.
    task automatic run_eval(input int a, input int al, input int b, input int bl,
                            input string req, input bit disturb = 0);
        int lat, yw, last;
        bit e;
        model_eval(a, al, b, bl, lat, e, yw);
        @(negedge clk);
        in_a = MAX_IN'(a); a_len = LW'(al); in_b = MAX_IN'(b); b_len = LW'(bl);
        start = 1;
        @(negedge clk);
        start = 0;
        last = disturb ? lat + 2 : lat;
        for (int c = 1; c <= last; c++) begin
            @(negedge clk);
            wr_en = 0; start = 0;
            chk(done == (c == lat), c > lat ? "R11" : req, "done", int'(done), int'(c == lat));
            if (c < lat) chk(busy == 1'b1, "R9", "busy", int'(busy), 1);
            if (c == lat) begin
                chk(err == e, req, "err", int'(err), int'(e));
                chk(int'(y) == yw, req, "y", int'(y), yw);
                chk(busy == 1'b0, "R9", "busy at done", int'(busy), 0);
            end
            if (disturb && c == 1) begin
                // clear op and a start during the run: both must be ignored (R11)
                wr_en = 1; wr_op = 2'd3; start = 1;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13: reset state
        chk(done == 0, "R13", "done", int'(done), 0);
        chk(err == 0, "R13", "err", int'(err), 0);
        chk(busy == 0, "R13", "busy", int'(busy), 0);
        chk(y == 0, "R13", "y", int'(y), 0);

        // Full adder: a = {y, x} at idx 2,3; carry-in at idx 4 (R5, R9)
        wr_hdr(3, 2);
        wr_node(5, 2, 3, 4);
        wr_node(6, 5, 4, 4);
        wr_node(7, 2, 3, 2);
        wr_node(8, 5, 4, 2);
        wr_node(9, 7, 8, 3);
        wr_sel(0, 6);
        wr_sel(1, 9);
        for (int p = 0; p < 8; p++) run_eval(p & 3, 2, p >> 2, 1, "R5");

        // Function sweep: all ten codes on idx 2 and 3 (R5)
        wr_clr();
        wr_hdr(2, 8);
        for (int f = 0; f < 10; f++) wr_node(4 + f, 2, 3, f);
        for (int k = 0; k < 8; k++) wr_sel(k, 4 + k);
        for (int p = 0; p < 4; p++) run_eval(p & 1, 1, p >> 1, 1, "R5");
        // codes 8, 9, constants and inputs (R1, R5)
        wr_sel(0, 12); wr_sel(1, 13); wr_sel(2, 0); wr_sel(3, 1);
        wr_sel(4, 2);  wr_sel(5, 3);  wr_sel(6, 1); wr_sel(7, 0);
        for (int p = 0; p < 4; p++) run_eval(p & 1, 1, p >> 1, 1, "R1");

        // Input mapping with no nodes, two operand splits (R2, R8)
        wr_clr();
        wr_hdr(5, 5);
        for (int k = 0; k < 8; k++) wr_sel(k, 2 + k);
        run_eval(3'b101, 3, 2'b10, 2, "R2");
        run_eval(3'b011, 3, 2'b01, 2, "R2");
        run_eval(2'b10, 2, 3'b110, 3, "R2");
        run_eval(8'hFF, 2, 8'hFF, 3, "R2");
        // bits above output count are zero (R8)
        wr_hdr(5, 3);
        run_eval(3'b111, 3, 2'b11, 2, "R8");

        // Input count mismatch (R3)
        run_eval(3, 2, 3, 2, "R3");
        // good run clears err (R10)
        run_eval(1, 3, 1, 2, "R10");

        // Source not strictly below own index (R4)
        wr_clr();
        wr_hdr(2, 1);
        wr_sel(0, 4);
        wr_node(4, 2, 3, 2);
        wr_node(5, 4, 5, 3);
        run_eval(1, 1, 1, 1, "R4");
        // node index out of range (R4)
        wr_clr();
        wr_node(27, 2, 3, 2);
        run_eval(1, 1, 1, 1, "R4");
        // duplicate node index (R6)
        wr_clr();
        wr_node(4, 2, 3, 3);
        wr_node(4, 2, 3, 2);
        run_eval(1, 1, 0, 1, "R6");
        // node on a declared input index (R6)
        wr_clr();
        wr_node(3, 2, 2, 2);
        run_eval(1, 1, 0, 1, "R6");
        // illegal function code (R7)
        wr_clr();
        wr_node(4, 2, 3, 4);
        wr_node(5, 4, 2, 12);
        run_eval(1, 1, 0, 1, "R7");
        // selector out of range (R8, R10)
        wr_clr();
        wr_node(4, 2, 3, 3);
        wr_sel(0, 30);
        run_eval(1, 1, 0, 1, "R8");

        // Table saturation: 17 appends, last ignored (R12)
        wr_clr();
        wr_hdr(2, 2);
        wr_node(4, 2, 3, 4);
        for (int i = 5; i <= 20; i++) wr_node(i, i - 1, 2, 4);
        wr_sel(0, 19);
        wr_sel(1, 3);
        run_eval(1, 1, 1, 1, "R12");
        // clear and start during a run are ignored (R11)
        run_eval(0, 1, 1, 1, "R11", 1);
        run_eval(1, 1, 0, 1, "R11");

        // Reset mid-run (R13)
        @(negedge clk);
        in_a = 1; a_len = 1; in_b = 0; b_len = 1; start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        model_reset();
        chk(done == 0, "R13", "done after reset", int'(done), 0);
        chk(busy == 0, "R13", "busy after reset", int'(busy), 0);
        chk(err == 0, "R13", "err after reset", int'(err), 0);
        chk(y == 0, "R13", "y after reset", int'(y), 0);
        run_eval(0, 0, 0, 0, "R13");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule